// File: doc/BRIEF.md
# DMA Channel Event Interrupt Collector

This block collects progress events from sixteen DMA channels and turns them into one interrupt line. Channels 0 through 7 are general-purpose channels and channels 8 through 15 are paced channels. Every channel raises two kinds of single-cycle pulse: one when half of its transfer is done and one when all of it is done. Each pulse latches a sticky bit in a 32-bit pending word. A 32-bit enable word chooses which of those bits may raise the interrupt.

Both words sit on a simple register bus. A request is one cycle with `req_valid` high. It is either a write (`req_write` high) or a read. The enable word lives at byte offset 0x0. The pending word lives at byte offset 0x4, and a write there clears every bit written as 1. Read data is registered: it shows the addressed word as it stood in the request cycle, and it holds until the next read. Interrupt service software reads the pending word, clears the bits it has handled, and can mask a source at any time by clearing its enable bit.

Top module: `dma_evt_irq`

## Requirements
- R1: After reset the enable word, the pending word, `irq_o` and `rd_data` are all zero.
- R2: A pulse on `half_evt[n]` sets pending bit 2n, and a pulse on `done_evt[n]` sets pending bit 2n+1. The set is seen from the next clock edge on.
- R3: The general-purpose channels 0..7 own pending and enable bits 0..15, and the paced channels 8..15 own bits 16..31. For example, the done pulse of channel 12 sets bit 25.
- R4: A write to offset 0x0 replaces the whole enable word, and a read of offset 0x0 returns it. The enable word does not change on any other request.
- R5: A write to offset 0x4 clears each pending bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0. Such a write never sets a bit.
- R6: An event sets its pending bit even when the matching enable bit is 0.
- R7: If an event and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R8: `irq_o` equals the OR over all 32 bits of (pending AND enable), sampled at the previous clock edge. It is a register output and lags the words by one cycle.
- R9: If software clears an enable bit while its pending bit stays set, that bit stops driving `irq_o` one cycle after the write takes effect.
- R10: A read returns the addressed word one cycle after the request. A read of any offset other than 0x0 or 0x4 returns zero. Writes to other offsets change nothing. `rd_data` keeps its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_evt | input | 16 | Half-done pulses, one per channel |
| done_evt | input | 16 | Done pulses, one per channel |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the request |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Directed sequences each set up one situation and check it on its own terms:
- a single half-done event on a general-purpose channel and a single done event on a paced channel, to check the bit pairing;
- a masked event, which separates latching from signalling;
- a same-cycle event and clear on one bit, which shows which side wins;
- partial write-1-to-clear masks, which show that bits written as 0 are untouched;
- dropping an enable bit under a live pending bit, which shows the masking and its one-cycle lag.

A long random phase then mixes sparse and dense event bursts with reads and writes to all four offsets. This exposes wrong bit positions, clear/set priority errors and stray decode of unused offsets against a cycle-level model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Which register a read request selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EN   = 2'd1,
        SEL_PEND = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irqc_evt_map.sv
module irqc_evt_map #(
    parameter int NUM_CH = 16,
    localparam int BITS  = 2 * NUM_CH
) (
    input  logic [NUM_CH-1:0] half_evt,
    input  logic [NUM_CH-1:0] done_evt,
    output logic [BITS-1:0]   evt_vec
);

    // Pair each channel onto two adjacent bits: half-done even, done odd
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pair
        assign evt_vec[2*ch]   = half_evt[ch];
        assign evt_vec[2*ch+1] = done_evt[ch];
    end

endmodule

// File: rtl/irqc_bus_dec.sv
module irqc_bus_dec
    import irqc_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] EN_OFS   = 'h0,
    parameter logic [ADDR_W-1:0] PEND_OFS = 'h4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              en_wr,
    output logic              pend_wr,
    output logic              rd_en,
    output reg_sel_e          rd_sel
);

    logic hit_en;
    logic hit_pend;

    always_comb begin
        hit_en   = (req_addr == EN_OFS);
        hit_pend = (req_addr == PEND_OFS);
        en_wr    = req_valid &&  req_write && hit_en;
        pend_wr  = req_valid &&  req_write && hit_pend;
        rd_en    = req_valid && !req_write;
        if (hit_en)
            rd_sel = SEL_EN;
        else if (hit_pend)
            rd_sel = SEL_PEND;
        else
            rd_sel = SEL_NONE;
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic            pend_wr,
    input  logic            rd_en,
    input  reg_sel_e        rd_sel,
    input  logic [BITS-1:0] wdata,
    input  logic [BITS-1:0] evt_vec,
    output logic [BITS-1:0] en_q_o,
    output logic [BITS-1:0] pend_q_o,
    output logic [BITS-1:0] rdata_o
);

    typedef struct packed {
        logic [BITS-1:0] en;
        logic [BITS-1:0] pend;
        logic [BITS-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic [BITS-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = pend_wr ? wdata : '0;

        if (en_wr)
            st_d.en = wdata;

        // Events win over a same-cycle clear
        st_d.pend = (st_q.pend & ~clr_mask) | evt_vec;

        if (rd_en) begin
            unique case (rd_sel)
                SEL_EN:   st_d.rdata = st_q.en;
                SEL_PEND: st_d.rdata = st_q.pend;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en_q_o   = st_q.en;
    assign pend_q_o = st_q.pend;
    assign rdata_o  = st_q.rdata;

endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out #(
    parameter int BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] en,
    input  logic [BITS-1:0] pend,
    output logic            irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(pend & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= irq_d;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/dma_evt_irq.sv
module dma_evt_irq
    import irqc_pkg::*;
#(
    parameter int NUM_GP    = 8,
    parameter int NUM_PACED = 8,
    parameter int ADDR_W    = 4,
    localparam int NUM_CH   = NUM_GP + NUM_PACED,
    localparam int BITS     = 2 * NUM_CH,
    localparam logic [ADDR_W-1:0] EN_OFS   = ADDR_W'(0),
    localparam logic [ADDR_W-1:0] PEND_OFS = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] half_evt,
    input  logic [NUM_CH-1:0] done_evt,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BITS-1:0]   req_wdata,
    output logic [BITS-1:0]   rd_data,
    output logic              irq_o
);

    logic [BITS-1:0] evt_vec;
    logic [BITS-1:0] en_vec;
    logic [BITS-1:0] pend_vec;
    logic            en_wr;
    logic            pend_wr;
    logic            rd_en;
    reg_sel_e        rd_sel;

    irqc_evt_map #(.NUM_CH(NUM_CH)) u_map (
        .half_evt (half_evt),
        .done_evt (done_evt),
        .evt_vec  (evt_vec)
    );

    irqc_bus_dec #(
        .ADDR_W   (ADDR_W),
        .EN_OFS   (EN_OFS),
        .PEND_OFS (PEND_OFS)
    ) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .en_wr     (en_wr),
        .pend_wr   (pend_wr),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel)
    );

    irqc_regs #(.BITS(BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .pend_wr  (pend_wr),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .wdata    (req_wdata),
        .evt_vec  (evt_vec),
        .en_q_o   (en_vec),
        .pend_q_o (pend_vec),
        .rdata_o  (rd_data)
    );

    irqc_irq_out #(.BITS(BITS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_vec),
        .pend  (pend_vec),
        .irq_o (irq_o)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 4,
    localparam int BITS  = 2 * NUM_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] half_evt,
    input logic [NUM_CH-1:0] done_evt,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BITS-1:0]   req_wdata,
    input logic [BITS-1:0]   en_vec,
    input logic [BITS-1:0]   pend_vec,
    input logic              irq_o
);

    logic [BITS-1:0] evts;
    logic [BITS-1:0] clr;
    logic            en_write;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ev
        assign evts[2*ch]   = half_evt[ch];
        assign evts[2*ch+1] = done_evt[ch];
    end

    assign clr      = (req_valid && req_write && req_addr == ADDR_W'(4)) ? req_wdata : '0;
    assign en_write = req_valid && req_write && req_addr == ADDR_W'(0);

    // R2
    evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evts != '0) |=> ((pend_vec & $past(evts)) == $past(evts)));

    // R5
    pend_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_vec) & ~pend_vec) & ~$past(clr)) == '0));

    // R5
    pend_rise_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_vec & ~$past(pend_vec)) & ~$past(evts)) == '0));

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_write |=> $stable(en_vec));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend_vec & en_vec))));

endmodule

bind dma_evt_irq irqc_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_evt  (half_evt),
    .done_evt  (done_evt),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .en_vec    (en_vec),
    .pend_vec  (pend_vec),
    .irq_o     (irq_o)
);

// File: tb/dma_evt_irq_tb.sv
module dma_evt_irq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] half_evt = '0;
    logic [15:0] done_evt = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] m_en = '0, m_pend = '0, m_rd = '0;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_evt_irq u_dut (
        .clk(clk), .rst_n(rst_n), .half_evt(half_evt), .done_evt(done_evt),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [31:0] pair(input logic [15:0] h, input logic [15:0] d);
        logic [31:0] e;
        for (int i = 0; i < NCH; i++) begin
            e[2*i]   = h[i];
            e[2*i+1] = d[i];
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive, update model at the edge, compare at the falling edge
    task automatic cyc(input logic [15:0] h, input logic [15:0] d, input logic v,
                       input logic w, input logic [3:0] a, input logic [31:0] wd);
        logic [31:0] clr;
        half_evt = h; done_evt = d; req_valid = v; req_write = w;
        req_addr = a; req_wdata = wd;
        @(posedge clk);
        clr = (v && w && a == 4'h4) ? wd : '0;
        m_irq = |(m_pend & m_en);
        if (v && !w)
            m_rd = (a == 4'h0) ? m_en : (a == 4'h4) ? m_pend : '0;
        m_pend = (m_pend & ~clr) | pair(h, d);
        if (v && w && a == 4'h0) m_en = wd;
        @(negedge clk);
        half_evt = '0; done_evt = '0; req_valid = 1'b0; req_write = 1'b0;
        chk("R8 irq vs model", {31'd0, irq_o}, {31'd0, m_irq});
        chk("R10 rd_data vs model", rd_data, m_rd);
    endtask

    task automatic idle();
        cyc('0, '0, 1'b0, 1'b0, 4'h0, '0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] wd);
        cyc('0, '0, 1'b1, 1'b1, a, wd);
    endtask

    task automatic rd(input logic [3:0] a);
        cyc('0, '0, 1'b1, 1'b0, a, '0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 irq at reset", {31'd0, irq_o}, 32'd0);
        chk("R1 rd_data at reset", rd_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'h0); chk("R1 enable reset", rd_data, 32'd0);
        rd(4'h4); chk("R1 pending reset", rd_data, 32'd0);

        // R2 / R6: half-done of channel 3 while masked -> bit 6
        cyc(16'h0008, '0, 1'b0, 1'b0, 4'h0, '0);
        rd(4'h4); chk("R2 half ch3 bit6", rd_data, 32'h0000_0040);
        chk("R6 masked no irq", {31'd0, irq_o}, 32'd0);
        // R3: paced channel 12 done -> bit 25
        cyc('0, 16'h1000, 1'b0, 1'b0, 4'h0, '0);
        rd(4'h4); chk("R3 done ch12 bit25", rd_data, 32'h0200_0040);

        // R4: enable write / readback
        wr(4'h0, 32'h0200_0000);
        rd(4'h0); chk("R4 enable readback", rd_data, 32'h0200_0000);
        chk("R8 irq asserted", {31'd0, irq_o}, 32'd1);

        // R5: clear bit 6 only, written zeros keep bit 25
        wr(4'h4, 32'h0000_0041);
        rd(4'h4); chk("R5 partial clear", rd_data, 32'h0200_0000);

        // R9: drop enable with pending still set
        wr(4'h0, 32'h0);
        chk("R9 irq lag one cycle", {31'd0, irq_o}, 32'd1);
        idle();
        chk("R9 irq masked", {31'd0, irq_o}, 32'd0);
        rd(4'h4); chk("R9 pending kept", rd_data, 32'h0200_0000);

        // R7: event and clear collide on bit 25
        cyc('0, 16'h1000, 1'b1, 1'b1, 4'h4, 32'h0200_0000);
        rd(4'h4); chk("R7 set wins", rd_data, 32'h0200_0000);

        // R10: unused offsets
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h8); chk("R10 unused reads zero", rd_data, 32'h0);
        idle(); chk("R10 rd_data holds", rd_data, 32'h0);
        rd(4'h0); chk("R10 enable untouched", rd_data, 32'h0);
        rd(4'h4); chk("R10 pending untouched", rd_data, 32'h0200_0000);

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] h, d;
            logic [31:0] wd;
            logic v, w;
            logic [3:0] a;
            if (k % 500 < 250) begin
                h = 16'($urandom & $urandom & $urandom);
                d = 16'($urandom & $urandom & $urandom);
            end else begin
                h = 16'($urandom);
                d = 16'($urandom);
            end
            v  = ($urandom % 3) != 0;
            w  = $urandom % 2 == 1;
            a  = 4'(($urandom % 4) * 4);
            wd = $urandom;
            cyc(h, d, v, w, a, wd);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule